// File: doc/BRIEF.md
# Two-Phase Signal Order Detector

This block watches two square-wave inputs, `x1` and `x0`, that have the same period but are shifted in phase. It reports which of the two leads. The input pair moves through a Gray sequence: only one bit changes between two consecutive samples. Each step therefore goes either forward or backward around a ring of four positions.

The block is a Mealy machine with four states. Each state records the last sampled input pair. The output `z` is decided in the same cycle that a step appears on the inputs:
- `z` is 0 when `x0` moved first, which is a forward step.
- `z` is 1 when `x1` moved first, which is a backward step.

A one-bit direction register keeps the last decision. `z` holds that value when the inputs do not move. It also holds that value when both bits jump at once, which is an illegal double step.

The inputs must already be synchronous to `clk`. The state register can be built in binary or in one-hot form, chosen by a parameter. Both forms give the same port behaviour.

Top module: `quad_order_detect`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the machine in the position for input pair 00 with the direction bit at 0. In the first cycle after reset, `z` is 1 only for the input pair (`x1`,`x0`) = 10, and 0 for the pairs 00, 01 and 11.
- R2: The forward ring of input pairs (`x1`,`x0`) is 00→01→11→10→00. When the present pair is the forward successor of the stored position, `z` is 0 in that same cycle.
- R3: When the present pair is the backward predecessor of the stored position (ring 00→10→11→01→00), `z` is 1 in that same cycle.
- R4: At every rising edge outside reset, the stored position becomes the present input pair. This includes illegal double steps, so later steps are judged from the new pair.
- R5: When the present pair equals the stored position, `z` equals the last decided direction.
- R6: When both input bits differ from the stored position, `z` equals the last decided direction.
- R7: At every rising edge outside reset, the direction bit takes the value `z` had in the cycle before the edge.
- R8: A reversal in the middle of a rotation changes `z` in the cycle of the first step that goes the other way.
- R9: The binary and one-hot state encodings, chosen by `ONEHOT_STATE`, give identical `z` for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x1 | input | 1 | Phase input, upper bit of the pair |
| x0 | input | 1 | Phase input, lower bit of the pair |
| z | output | 1 | Direction: 0 when x0 leads, 1 when x1 leads |

## Verification
`z` depends combinationally on the present inputs and on the position registered at the last edge. The direction result is therefore due in the same cycle as the step, with no register delay. The bench drives each input pair just after a falling edge and samples `z` a short time later, before the next rising edge. The stored position and the direction bit change at the following rising edge, and only then does the bench's model advance. Their effect is checked one cycle later, through the `z` seen for the next pair.

// File: rtl/qdir_pkg.sv
package qdir_pkg;

   localparam int PAIR_W     = 2;
   localparam int NUM_STATES = 4;
   localparam int IDX_W      = $clog2(NUM_STATES);

   // Positions are encoded as the input pair (x1,x0) they stand for.
   typedef enum logic [PAIR_W-1:0] {
      POS_A = 2'b00,
      POS_B = 2'b01,
      POS_C = 2'b11,
      POS_D = 2'b10
   } pos_t;

   // Forward ring: x0 moves first.
   function automatic logic [PAIR_W-1:0] step_fwd(input logic [PAIR_W-1:0] c);
      case (c)
         2'b00:   return 2'b01;
         2'b01:   return 2'b11;
         2'b11:   return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   // Backward ring: x1 moves first.
   function automatic logic [PAIR_W-1:0] step_bwd(input logic [PAIR_W-1:0] c);
      case (c)
         2'b00:   return 2'b10;
         2'b10:   return 2'b11;
         2'b11:   return 2'b01;
         default: return 2'b00;
      endcase
   endfunction

   // Ring index of a pair (A=0, B=1, C=2, D=3), used by the one-hot variant.
   function automatic logic [IDX_W-1:0] code_to_idx(input logic [PAIR_W-1:0] c);
      case (c)
         2'b00:   return 2'd0;
         2'b01:   return 2'd1;
         2'b11:   return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

   function automatic logic [PAIR_W-1:0] idx_to_code(input logic [IDX_W-1:0] i);
      case (i)
         2'd0:    return 2'b00;
         2'd1:    return 2'b01;
         2'd2:    return 2'b11;
         default: return 2'b10;
      endcase
   endfunction

endpackage

// File: rtl/qdir_step_classify.sv
module qdir_step_classify
   import qdir_pkg::*;
(
   input  logic [PAIR_W-1:0] pos_code,
   input  logic [PAIR_W-1:0] pair_in,
   output logic              is_fwd,
   output logic              is_bwd,
   output logic              is_hold,
   output logic              is_jump
);

   always_comb begin
      is_fwd  = (pair_in == step_fwd(pos_code));
      is_bwd  = (pair_in == step_bwd(pos_code));
      is_hold = (pair_in == pos_code);
      is_jump = (pair_in == ~pos_code);
   end

endmodule

// File: rtl/qdir_state_reg.sv
module qdir_state_reg
   import qdir_pkg::*;
#(
   parameter bit ONEHOT = 1'b0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [PAIR_W-1:0] nxt_code,
   output logic [PAIR_W-1:0] cur_code
);

   generate
      if (ONEHOT) begin : g_onehot
         logic [NUM_STATES-1:0] oh_q;
         logic [NUM_STATES-1:0] oh_d;

         always_comb begin
            oh_d = '0;
            oh_d[code_to_idx(nxt_code)] = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               oh_q <= '0;
               oh_q[code_to_idx(POS_A)] <= 1'b1;
            end else begin
               oh_q <= oh_d;
            end
         end

         always_comb begin
            cur_code = '0;
            for (int i = 0; i < NUM_STATES; i++) begin
               if (oh_q[i]) cur_code = cur_code | idx_to_code(IDX_W'(i));
            end
         end
      end else begin : g_binary
         logic [PAIR_W-1:0] bin_q;

         always_ff @(posedge clk) begin
            if (rst) bin_q <= POS_A;
            else     bin_q <= nxt_code;
         end

         assign cur_code = bin_q;
      end
   endgenerate

endmodule

// File: rtl/qdir_direction.sv
module qdir_direction #(
   parameter bit RESET_DIR = 1'b0
)(
   input  logic clk,
   input  logic rst,
   input  logic is_fwd,
   input  logic is_bwd,
   output logic dir_out
);

   logic dir_q;

   // Mealy decision: a legal step decides now, anything else keeps history.
   always_comb begin
      if (is_fwd)      dir_out = 1'b0;
      else if (is_bwd) dir_out = 1'b1;
      else             dir_out = dir_q;
   end

   always_ff @(posedge clk) begin
      if (rst) dir_q <= RESET_DIR;
      else     dir_q <= dir_out;
   end

endmodule

// File: rtl/quad_order_detect.sv
module quad_order_detect
   import qdir_pkg::*;
#(
   parameter int ONEHOT_STATE = 0
)(
   input  logic clk,
   input  logic rst,
   input  logic x1,
   input  logic x0,
   output logic z
);

   generate
      if (!(ONEHOT_STATE == 0 || ONEHOT_STATE == 1)) begin : g_bad_enc
         $error("quad_order_detect: ONEHOT_STATE must be 0 or 1");
      end
   endgenerate

   localparam bit USE_OH = (ONEHOT_STATE == 1);

   logic [PAIR_W-1:0] pair_now;
   logic [PAIR_W-1:0] pos_code;
   logic              fwd, bwd, hold, jump;

   assign pair_now = {x1, x0};

   qdir_state_reg #(.ONEHOT(USE_OH)) u_state (
      .clk      (clk),
      .rst      (rst),
      .nxt_code (pair_now),
      .cur_code (pos_code)
   );

   qdir_step_classify u_class (
      .pos_code (pos_code),
      .pair_in  (pair_now),
      .is_fwd   (fwd),
      .is_bwd   (bwd),
      .is_hold  (hold),
      .is_jump  (jump)
   );

   qdir_direction #(.RESET_DIR(1'b0)) u_dir (
      .clk     (clk),
      .rst     (rst),
      .is_fwd  (fwd),
      .is_bwd  (bwd),
      .dir_out (z)
   );

   // hold and jump only document the class; direction keeps history for both.
   logic unused_cls;
   assign unused_cls = hold ^ jump;

endmodule

// File: rtl/qdir_checker.sv
module qdir_checker
   import qdir_pkg::*;
(
   input logic clk,
   input logic rst,
   input logic x1,
   input logic x0,
   input logic z
);

   logic [PAIR_W-1:0] pr;
   assign pr = {x1, x0};

   // R1: first cycle after reset, position 00 and direction 0
   p_reset_pos_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (z == (x1 & ~x0)));

   // R2: forward step drives z low in the same cycle
   p_fwd_low_r2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && pr == step_fwd($past(pr))) |-> !z);

   // R3: backward step drives z high in the same cycle
   p_bwd_high_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && pr == step_bwd($past(pr))) |-> z);

   // R5 and R7: no movement keeps the last decision
   p_hold_keep_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $stable(pr)) |-> (z == $past(z)));

   // R6 and R4: a double step keeps the last decision
   p_jump_keep_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && pr == ~$past(pr)) |-> (z == $past(z)));

endmodule

bind quad_order_detect qdir_checker u_chk (
   .clk (clk),
   .rst (rst),
   .x1  (x1),
   .x0  (x0),
   .z   (z)
);

// File: tb/quad_order_detect_tb.sv
module quad_order_detect_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x1  = 1'b0;
   logic x0  = 1'b0;
   logic z_bin, z_oh;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [1:0] m_pos;
   logic       m_dir;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_order_detect #(.ONEHOT_STATE(0)) u_dut (
      .clk(clk), .rst(rst), .x1(x1), .x0(x0), .z(z_bin));

   quad_order_detect #(.ONEHOT_STATE(1)) u_dut_oh (
      .clk(clk), .rst(rst), .x1(x1), .x0(x0), .z(z_oh));

   function automatic logic [1:0] ring_next(input logic [1:0] c);
      case (c)
         2'b00: ring_next = 2'b01;
         2'b01: ring_next = 2'b11;
         2'b11: ring_next = 2'b10;
         default: ring_next = 2'b00;
      endcase
   endfunction

   function automatic logic [1:0] ring_prev(input logic [1:0] c);
      case (c)
         2'b00: ring_prev = 2'b10;
         2'b10: ring_prev = 2'b11;
         2'b11: ring_prev = 2'b01;
         default: ring_prev = 2'b00;
      endcase
   endfunction

   function automatic logic expect_z(input logic [1:0] pos, input logic [1:0] pr,
                                     input logic dir);
      if (pr == ring_next(pos))      expect_z = 1'b0;
      else if (pr == ring_prev(pos)) expect_z = 1'b1;
      else                           expect_z = dir;
   endfunction

   function automatic string tag_of(input logic [1:0] pos, input logic [1:0] pr);
      if (pr == ring_next(pos))      tag_of = "R2";
      else if (pr == ring_prev(pos)) tag_of = "R3";
      else if (pr == pos)            tag_of = "R5";
      else                           tag_of = "R6";
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: z actual %b expected %b (time %0t)", req, act, exp, $time);
      end
   endtask

   // Drive a pair after the falling edge, check z, then let the edge commit it.
   task automatic apply(input logic [1:0] pr, input string req_override);
      logic e;
      string t;
      @(negedge clk);
      {x1, x0} = pr;
      #2;
      e = expect_z(m_pos, pr, m_dir);
      t = (req_override.len() != 0) ? req_override : tag_of(m_pos, pr);
      check(t, z_bin, e);
      n_checks++;
      if (z_oh !== z_bin) begin
         n_fail++;
         $display("FAIL R9: one-hot z actual %b expected %b", z_oh, z_bin);
      end
      @(posedge clk);
      m_pos = pr;   // R4
      m_dir = e;    // R7
   endtask

   task automatic do_reset(input logic [1:0] pr);
      @(negedge clk);
      rst = 1'b1;
      {x1, x0} = pr;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_pos = 2'b00;
      m_dir = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [1:0] cur;
      bit         fwd_mode;
      int unsigned r;
      m_pos = 2'b00;
      m_dir = 1'b0;
      r = $urandom(32'd2024);

      // R1: each possible first pair after reset
      do_reset(2'b00); apply(2'b00, "R1");
      do_reset(2'b00); apply(2'b01, "R1");
      do_reset(2'b00); apply(2'b10, "R1");
      do_reset(2'b00); apply(2'b11, "R1");

      // R2: full forward rotation, then R5 hold keeps 0 (R7)
      do_reset(2'b00);
      apply(2'b01, "R2"); apply(2'b11, "R2"); apply(2'b10, "R2"); apply(2'b00, "R2");
      apply(2'b00, "R5");
      // R8: reversal in mid rotation flips z in the same cycle
      apply(2'b01, "R2"); apply(2'b00, "R8"); apply(2'b10, "R3");
      apply(2'b10, "R5"); apply(2'b10, "R7");
      // R6: double step keeps 1, then R4: judged from new position
      apply(2'b01, "R6");
      apply(2'b11, "R4");
      apply(2'b11, "R5");
      apply(2'b00, "R6");
      apply(2'b10, "R3"); apply(2'b11, "R3"); apply(2'b01, "R3"); apply(2'b00, "R3");
      apply(2'b01, "R8");

      // Constrained random: mostly legal steps with sticky direction
      cur = m_pos;
      fwd_mode = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         r = $urandom;
         if (r % 16 == 0) fwd_mode = ~fwd_mode;
         case ((r >> 4) % 10)
            0, 1:    cur = cur;
            2:       cur = ~cur;
            default: cur = fwd_mode ? ring_next(cur) : ring_prev(cur);
         endcase
         apply(cur, "");
      end

      finish_run();
   end

endmodule